// File: doc/BRIEF.md
# Registered-Address Scratch Memory

A small word-addressed memory with a register on each side of the array. An address register sits in front and loads the address input on a rising edge when its load enable is high. Writes and lookups both use the address that register holds, not the live address input. A result register sits behind the array and drives the read data output.

A write stores the data input in the word the address register names, on a rising clock edge with the write strobe high. A lookup copies that word into the result register on a rising edge, but only when the lookup strobe and the result-register enable are both high. At all other times the output keeps its value. Every state change happens on a rising edge, so a read takes two edges from a new address on the input to the word on the output: one to load the address register and one to load the result register.

The default build has 16 words of 4 bits with a 4-bit address. A write and a lookup in the same cycle return the word as it was before that write.

Top module: `latched_ram`

## Requirements
- R1: A synchronous active-high reset clears the address register and the read data output to zero. A write issued right after reset, without loading an address, lands in word 0.
- R2: The address register takes `addr_in` on a rising edge when `addr_ld` is 1. When `addr_ld` is 0 it keeps its value, whatever `addr_in` does.
- R3: When `wr_en` is 1 on a rising edge, `wr_data` is stored in the word the address register held before that edge.
- R4: When `wr_en` is 0, `wr_data` has no effect on any stored word.
- R5: When `lookup` and `rd_en` are both 1 on a rising edge, `rd_data` shows the stored word at the held address after that edge and not before it.
- R6: When `lookup` or `rd_en` is 0 on a rising edge, `rd_data` keeps its previous value. This includes cycles in which a write takes place.
- R7: When a write and a lookup happen on the same edge, `rd_data` shows the word as it was before the write. The new word appears on the next lookup.
- R8: Each of the 16 words keeps its own value: filling every address and reading every address back returns each word's own data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | ADDR_W (4) | Address presented to the address register |
| addr_ld | input | 1 | Load enable for the address register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W (4) | Word to store |
| lookup | input | 1 | Read request |
| rd_en | input | 1 | Enable for the result register |
| rd_data | output | DATA_W (4) | Contents of the result register |

## Verification
An address register that loads when it should not, or fails to load when it should, sends the next write or lookup to the wrong word. This shows on `rd_data` one edge after the following lookup. A wrong stored word only shows when its address is looked up, so the bench writes every address and then reads every address back. A result register that loads at the wrong time shows as an output change within one cycle of a held cycle. Read ordering is probed with a same-edge write and lookup, which must return the old word first and the new word on the next lookup.

// File: rtl/latched_ram_pkg.sv
package latched_ram_pkg;
  localparam int unsigned DEF_ADDR_W = 4;
  localparam int unsigned DEF_DATA_W = 4;

  function automatic int unsigned word_count(input int unsigned aw);
    return 32'd1 << aw;
  endfunction
endpackage

// File: rtl/addr_hold.sv
module addr_hold #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(q));
  // R2
  addr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && ld) |=> (q == $past(d)));
endmodule

// File: rtl/word_store.sv
module word_store #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] din,
  input  logic              re,
  output logic [DATA_W-1:0] dout
);
  localparam int unsigned DEPTH = latched_ram_pkg::word_count(ADDR_W);

  logic [DATA_W-1:0] mem [DEPTH];

  // array without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= din;
  end

  // read-first registered output with enable and synchronous reset
  always_ff @(posedge clk) begin
    if (rst)     dout <= '0;
    else if (re) dout <= mem[addr];
  end

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(dout));
  // R1
  out_reset_chk: assert property (@(posedge clk)
    rst |=> (dout == '0));
endmodule

// File: rtl/latched_ram.sv
module latched_ram #(
  parameter int unsigned ADDR_W = latched_ram_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W = latched_ram_pkg::DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              addr_ld,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              lookup,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);
  logic [ADDR_W-1:0] held_addr;
  logic              rd_fire;

  assign rd_fire = lookup & rd_en;

  addr_hold #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .ld(addr_ld), .d(addr_in), .q(held_addr)
  );

  word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst), .addr(held_addr), .we(wr_en), .din(wr_data),
    .re(rd_fire), .dout(rd_data)
  );

  // R1
  addr_reset_chk: assert property (@(posedge clk)
    rst |=> (held_addr == '0));
  // R6
  port_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(lookup && rd_en) |=> $stable(rd_data));
endmodule

// File: tb/tb_latched_ram.sv
module tb_latched_ram;
  localparam int AW = 4;
  localparam int DW = 4;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic          addr_ld = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          lookup = 1'b0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [N];

  always #5 clk = ~clk;

  latched_ram #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .addr_in(addr_in), .addr_ld(addr_ld),
    .wr_en(wr_en), .wr_data(wr_data), .lookup(lookup), .rd_en(rd_en),
    .rd_data(rd_data)
  );

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'((a * 7 + 3 + k * 5) % N);
  endfunction

  task automatic check(input string req, input logic [DW-1:0] exp);
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
    end
  endtask

  // one cycle: drive at falling edge, sample 1 ns after the rising edge
  task automatic step(input logic al, input int a, input logic we,
                      input int d, input logic lk, input logic re);
    @(negedge clk);
    addr_ld = al; addr_in = AW'(a); wr_en = we; wr_data = DW'(d);
    lookup = lk; rd_en = re;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(1'b0, 0, 1'b0, 0, 1'b0, 1'b0);
  endtask

  task automatic write_at(input int a, input int d);
    step(1'b1, a, 1'b0, 0, 1'b0, 1'b0);
    step(1'b0, 0, 1'b1, d, 1'b0, 1'b0);
    model[a] = DW'(d);
  endtask

  task automatic read_at(input int a);
    step(1'b1, a, 1'b0, 0, 1'b0, 1'b0);
    step(1'b0, 0, 1'b0, 0, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset output", '0);
    @(negedge clk); rst = 1'b0;

    // R1: the address register resets to 0, so an unaddressed write lands in word 0
    step(1'b0, 9, 1'b1, 9, 1'b0, 1'b0);
    model[0] = 4'h9;
    step(1'b0, 9, 1'b0, 0, 1'b1, 1'b1);
    check("R1 write after reset in word 0", 4'h9);
    read_at(0);
    check("R1 word 0 read back", 4'h9);

    // R8 and R3: fill every address, then read every address back
    for (int a = 0; a < N; a++) write_at(a, pat(a, 0));
    for (int a = 0; a < N; a++) begin
      read_at(a);
      check("R8 sweep read", model[a]);
    end
    for (int a = N - 1; a >= 0; a--) write_at(a, pat(a, 1));
    for (int a = 0; a < N; a++) begin
      read_at(a);
      check("R3 second pattern", model[a]);
    end

    // R5: the output changes on the lookup edge and not before it
    write_at(6, 4'hA);
    write_at(7, 4'h5);
    read_at(6);
    check("R5 first lookup", 4'hA);
    step(1'b1, 7, 1'b0, 0, 1'b0, 1'b0);
    @(negedge clk);
    lookup = 1'b1; rd_en = 1'b1;
    check("R5 before lookup edge", 4'hA);
    @(posedge clk); #1;
    check("R5 after lookup edge", 4'h5);

    // R2: address input changes are ignored while addr_ld is 0
    read_at(2);
    step(1'b0, 11, 1'b0, 0, 1'b1, 1'b1);
    check("R2 held address lookup", model[2]);
    step(1'b0, 11, 1'b1, 4'hC, 1'b0, 1'b0);
    model[2] = 4'hC;
    read_at(11);
    check("R2 other word untouched", model[11]);
    read_at(2);
    check("R2 write to held address", 4'hC);

    // R4: with wr_en low the data input changes nothing
    step(1'b1, 4, 1'b0, 0, 1'b0, 1'b0);
    for (int d = 0; d < N; d++) step(1'b0, 0, 1'b0, d, 1'b0, 1'b0);
    step(1'b0, 0, 1'b0, 0, 1'b1, 1'b1);
    check("R4 word unchanged", model[4]);

    // R6: the output holds unless lookup and rd_en are both high
    read_at(3);
    step(1'b1, 8, 1'b0, 0, 1'b1, 1'b0);
    check("R6 lookup without rd_en", model[3]);
    step(1'b0, 8, 1'b0, 0, 1'b0, 1'b1);
    check("R6 rd_en without lookup", model[3]);
    step(1'b0, 8, 1'b1, 4'h1, 1'b0, 1'b1);
    model[8] = 4'h1;
    check("R6 write leaves output", model[3]);

    // R7: write and lookup on the same edge return the old word
    write_at(13, 4'h2);
    step(1'b1, 13, 1'b0, 0, 1'b0, 1'b0);
    step(1'b0, 0, 1'b1, 4'hE, 1'b1, 1'b1);
    check("R7 old word on same edge", 4'h2);
    model[13] = 4'hE;
    step(1'b0, 0, 1'b0, 0, 1'b1, 1'b1);
    check("R7 new word on next lookup", 4'hE);

    // R1: reset mid-run clears output and address register
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R1 output after second reset", '0);
    @(negedge clk); rst = 1'b0;
    step(1'b0, 5, 1'b0, 0, 1'b1, 1'b1);
    check("R1 address zero after second reset", model[0]);
    idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule